// File: doc/BRIEF.md
# Maskable Read-Clear Interrupt Unit

This block gathers single-cycle event pulses from accessory detection logic into two sticky status registers. Each status bit has its own mask bit, and one global mask bit sits in bit 0 of a control register. The block drives an active-low, push-pull interrupt line toward the host processor. The host reaches the status, mask and control registers through a plain register-file access port. That port is meant to be driven by a serial target controller that this block does not contain. Reading a status register returns its contents and empties it in the same step.

The global mask comes out of reset set. The line is also held asserted after every reset, even with nothing pending. It is released only when the host writes 0 to the global mask, which tells the block that software has taken over. Events that are masked, by a per-bit mask or by the global mask, are still recorded and can be read. They only stop driving the line.

The register port and the interrupt line are sideband control signals, so they carry no valid/ready handshake. A read or a write takes effect at the clock edge where its enable is high. Read data is registered and is valid from the following cycle onward.

Top module: `irq_unit`

## Requirements
- R1: After reset, both status registers and both mask registers read 0x00, the control register reads 0x01 (global mask set), and `irq_n` is 0.
- R2: Status group 1 latches attach in bit 0 and detach in bit 1. A bit stays set after its event pulse ends.
- R3: Status group 2 latches charger-with-A/V in bit 0, reserved-device attach in bit 1, ADC change in bit 2 and connect in bit 5. All other bits of both status registers read 0.
- R4: A read of a status register returns its contents on `rd_data` in the cycle after `rd_en` and clears that register at the same edge.
- R5: An event that arrives in the same cycle as a read-clear of its register stays pending: it is absent from that read and present in the next one.
- R6: The ADC-change event is latched only while `raw_report_en` is 1. When it is 0 the pulse leaves no status bit and does not move `irq_n`.
- R7: A mask bit of 1 stops the matching status bit from driving `irq_n`, but the event is still latched and readable.
- R8: Once the post-reset hold is released, `irq_n` is 0 exactly when some status bit is set with its mask bit at 0 and the global mask is 0. It is 1 whenever the global mask is 1.
- R9: From reset, `irq_n` stays 0 regardless of pending events until the host writes 0 to control bit 0. Setting the global mask again afterwards does not bring the hold back.
- R10: Writes to the status registers change nothing.
- R11: The mask registers keep only their defined bit positions (0x03 for group 1, 0x27 for group 2) and the control register keeps only bit 0. Undefined bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the digital logic |
| ev_attach | input | 1 | Accessory attach event pulse |
| ev_detach | input | 1 | Accessory detach event pulse |
| ev_chg_av | input | 1 | Charger found while an A/V cable is attached |
| ev_rsv_attach | input | 1 | Reserved accessory attached |
| ev_adc_change | input | 1 | ID resistance code changed |
| ev_connect | input | 1 | Signal switch closed |
| raw_report_en | input | 1 | 1 lets ADC-change events be latched |
| acc_addr | input | ADDR_W | Register address for a read or write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, which also clears a status register |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| irq_n | output | 1 | Active-low push-pull interrupt line |

## Verification
The hardest case to reach from the ports is an event pulse landing on the exact clock edge that read-clears its register. The bench raises `rd_en` and the attach pulse on the same falling edge, so both are sampled by one rising edge. It then expects an empty read followed by a second read that shows the attach bit. The post-reset hold is also hard to tell apart from a real pending interrupt. The bench therefore checks that `irq_n` stays low with all status registers empty. It then checks that setting the global mask again after release leaves the line high.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int REG_W = 8;

  // bits that physically exist in each status/mask group
  localparam logic [REG_W-1:0] GRP1_KEEP = 8'h03;
  localparam logic [REG_W-1:0] GRP2_KEEP = 8'h27;

  // group 1 positions
  localparam int B_ATTACH = 0;
  localparam int B_DETACH = 1;
  // group 2 positions
  localparam int B_CHG_AV = 0;
  localparam int B_RSV    = 1;
  localparam int B_ADC    = 2;
  localparam int B_CONN   = 5;
  // control register position of the global mask
  localparam int B_GMASK  = 0;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flag_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_live
      logic q;
      // a set in the clearing cycle wins, so no event is dropped
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q & ~clr_i) | set_i[i];
      end
      assign flag_o[i] = q;
    end else begin : g_tie
      logic unused_set;
      assign unused_set = set_i[i];
      assign flag_o[i]  = 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_live
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= 1'b0;
        else if (we_i) q <= d_i[i];
      end
      assign q_o[i] = q;
    end else begin : g_tie
      logic unused_d;
      assign unused_d = d_i[i];
      assign q_o[i]   = 1'b0;
    end
  end
endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we_i,
  input  logic gmask_d_i,
  input  logic pend_i,
  output logic gmask_o,
  output logic hold_o,
  output logic irq_n_o
);
  logic gmask_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask_q <= 1'b1;
      hold_q  <= 1'b1;
    end else if (ctrl_we_i) begin
      gmask_q <= gmask_d_i;
      if (!gmask_d_i) hold_q <= 1'b0;
    end
  end

  assign gmask_o = gmask_q;
  assign hold_o  = hold_q;
  assign irq_n_o = ~(hold_q | (pend_i & ~gmask_q));
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_FLAG1 = 'h10,
  parameter logic [ADDR_W-1:0] A_FLAG2 = 'h11,
  parameter logic [ADDR_W-1:0] A_MASK1 = 'h12,
  parameter logic [ADDR_W-1:0] A_MASK2 = 'h13,
  parameter logic [ADDR_W-1:0] A_CTRL  = 'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_attach,
  input  logic              ev_detach,
  input  logic              ev_chg_av,
  input  logic              ev_rsv_attach,
  input  logic              ev_adc_change,
  input  logic              ev_connect,
  input  logic              raw_report_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq_n
);
  logic hit_f1, hit_f2, hit_m1, hit_m2, hit_ctl;
  logic [REG_W-1:0] set1, set2, flag1_q, flag2_q, mask1_q, mask2_q;
  logic gmask_q, hold_q, pend_any;
  logic [REG_W-1:0] rd_mux;

  assign hit_f1  = (acc_addr == A_FLAG1);
  assign hit_f2  = (acc_addr == A_FLAG2);
  assign hit_m1  = (acc_addr == A_MASK1);
  assign hit_m2  = (acc_addr == A_MASK2);
  assign hit_ctl = (acc_addr == A_CTRL);

  always_comb begin
    set1 = '0;
    set1[B_ATTACH] = ev_attach;
    set1[B_DETACH] = ev_detach;
    set2 = '0;
    set2[B_CHG_AV] = ev_chg_av;
    set2[B_RSV]    = ev_rsv_attach;
    set2[B_ADC]    = ev_adc_change & raw_report_en;
    set2[B_CONN]   = ev_connect;
  end

  irq_flag_bank #(.W(REG_W), .KEEP(GRP1_KEEP)) u_flag1 (
    .clk(clk), .rst_n(rst_n), .set_i(set1), .clr_i(rd_en & hit_f1), .flag_o(flag1_q));
  irq_flag_bank #(.W(REG_W), .KEEP(GRP2_KEEP)) u_flag2 (
    .clk(clk), .rst_n(rst_n), .set_i(set2), .clr_i(rd_en & hit_f2), .flag_o(flag2_q));

  irq_mask_reg #(.W(REG_W), .KEEP(GRP1_KEEP)) u_mask1 (
    .clk(clk), .rst_n(rst_n), .we_i(wr_en & hit_m1), .d_i(wr_data), .q_o(mask1_q));
  irq_mask_reg #(.W(REG_W), .KEEP(GRP2_KEEP)) u_mask2 (
    .clk(clk), .rst_n(rst_n), .we_i(wr_en & hit_m2), .d_i(wr_data), .q_o(mask2_q));

  assign pend_any = (|(flag1_q & ~mask1_q)) | (|(flag2_q & ~mask2_q));

  irq_line_drive u_line (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we_i(wr_en & hit_ctl), .gmask_d_i(wr_data[B_GMASK]),
    .pend_i(pend_any),
    .gmask_o(gmask_q), .hold_o(hold_q), .irq_n_o(irq_n));

  always_comb begin
    rd_mux = '0;
    if (hit_f1)  rd_mux = flag1_q;
    if (hit_f2)  rd_mux = flag2_q;
    if (hit_m1)  rd_mux = mask1_q;
    if (hit_m2)  rd_mux = mask2_q;
    if (hit_ctl) rd_mux[B_GMASK] = gmask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_FLAG1 = 'h10,
  parameter logic [ADDR_W-1:0] A_FLAG2 = 'h11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_attach,
  input logic              ev_detach,
  input logic              raw_report_en,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [7:0]        flag1,
  input logic [7:0]        flag2,
  input logic              gmask,
  input logic              hold,
  input logic              irq_n
);
  // R5
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_attach |=> flag1[0]);

  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && acc_addr == A_FLAG1 && !ev_attach && !ev_detach) |=> (flag1 == 8'h00));

  // R6
  adc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_report_en && rd_en && acc_addr == A_FLAG2) |=> !flag2[2]);

  // R8
  gmask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gmask && !hold) |-> irq_n);

  // R9
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !irq_n);

  // R10
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_addr == A_FLAG1 && !rd_en && !ev_attach && !ev_detach)
      |=> (flag1 == $past(flag1)));
endmodule

bind irq_unit irq_unit_chk #(.ADDR_W(ADDR_W), .A_FLAG1(A_FLAG1), .A_FLAG2(A_FLAG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_attach(ev_attach), .ev_detach(ev_detach),
  .raw_report_en(raw_report_en), .rd_en(rd_en), .wr_en(wr_en), .acc_addr(acc_addr),
  .flag1(flag1_q), .flag2(flag2_q), .gmask(gmask_q), .hold(hold_q), .irq_n(irq_n));

// File: tb/sim_irq_unit.sv
module sim_irq_unit;
  localparam logic [7:0] F1 = 8'h10, F2 = 8'h11, M1 = 8'h12, M2 = 8'h13, CT = 8'h14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_attach = 0, ev_detach = 0, ev_chg_av = 0, ev_rsv_attach = 0;
  logic ev_adc_change = 0, ev_connect = 0, raw_report_en = 1;
  logic [7:0] acc_addr = '0, wr_data = '0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] rd_data;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .ev_attach(ev_attach), .ev_detach(ev_detach),
    .ev_chg_av(ev_chg_av), .ev_rsv_attach(ev_rsv_attach), .ev_adc_change(ev_adc_change),
    .ev_connect(ev_connect), .raw_report_en(raw_report_en), .acc_addr(acc_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); acc_addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); acc_addr = a; wr_data = v; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  // ev = {connect, adc, rsv, chg_av, detach, attach}
  task automatic pulse(input logic [5:0] ev);
    @(negedge clk);
    {ev_connect, ev_adc_change, ev_rsv_attach, ev_chg_av, ev_detach, ev_attach} = ev;
    @(negedge clk);
    {ev_connect, ev_adc_change, ev_rsv_attach, ev_chg_av, ev_detach, ev_attach} = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq_n after reset", {7'b0, irq_n}, 8'h00);
    rd(F1, d); check("R1 flag1 reset", d, 8'h00);
    rd(F2, d); check("R1 flag2 reset", d, 8'h00);
    rd(M1, d); check("R1 mask1 reset", d, 8'h00);
    rd(M2, d); check("R1 mask2 reset", d, 8'h00);
    rd(CT, d); check("R1 ctrl reset", d, 8'h01);
  endtask

  task automatic t_hold();
    repeat (5) @(negedge clk);
    check("R9 held low with nothing pending", {7'b0, irq_n}, 8'h00);
    wr(CT, 8'h00);
    check("R9 released by clearing global mask", {7'b0, irq_n}, 8'h01);
    wr(CT, 8'h01);
    check("R9 hold not restored by remask", {7'b0, irq_n}, 8'h01);
    wr(CT, 8'h00);
  endtask

  task automatic t_flag1();
    logic [7:0] d;
    pulse(6'b000001);
    repeat (2) @(negedge clk);
    check("R8 attach asserts line", {7'b0, irq_n}, 8'h00);
    rd(F1, d); check("R2 attach bit0 sticky", d, 8'h01);
    check("R4 line released after read-clear", {7'b0, irq_n}, 8'h01);
    rd(F1, d); check("R4 second read empty", d, 8'h00);
    pulse(6'b000010);
    rd(F1, d); check("R2 detach bit1", d, 8'h02);
  endtask

  task automatic t_flag2();
    logic [7:0] d;
    raw_report_en = 1;
    pulse(6'b111100);
    rd(F2, d); check("R3 group2 positions", d, 8'h27);
    raw_report_en = 0;
    pulse(6'b010000);
    check("R6 gated adc leaves line high", {7'b0, irq_n}, 8'h01);
    rd(F2, d); check("R6 adc not latched when raw off", d, 8'h00);
    raw_report_en = 1;
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(M1, 8'hFF); rd(M1, d); check("R11 mask1 defined bits", d, 8'h03);
    wr(M2, 8'hFF); rd(M2, d); check("R11 mask2 defined bits", d, 8'h27);
    wr(CT, 8'hFE); rd(CT, d); check("R11 ctrl defined bits", d, 8'h00);
    wr(M2, 8'h00);
    wr(M1, 8'h01);
    pulse(6'b000001);
    check("R7 masked attach keeps line high", {7'b0, irq_n}, 8'h01);
    pulse(6'b000010);
    check("R7 unmasked detach drives line", {7'b0, irq_n}, 8'h00);
    rd(F1, d); check("R7 masked event still latched", d, 8'h03);
    wr(M1, 8'h00);
  endtask

  task automatic t_gmask();
    logic [7:0] d;
    pulse(6'b100000);
    check("R8 connect drives line", {7'b0, irq_n}, 8'h00);
    wr(CT, 8'h01);
    check("R8 global mask quiets line", {7'b0, irq_n}, 8'h01);
    wr(CT, 8'h00);
    check("R8 unmask reasserts line", {7'b0, irq_n}, 8'h00);
    rd(F2, d); check("R8 connect read", d, 8'h20);
    check("R8 line high when empty", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    @(negedge clk); acc_addr = F1; rd_en = 1; ev_attach = 1;
    @(negedge clk); rd_en = 0; ev_attach = 0;
    check("R5 colliding read sees old value", rd_data, 8'h00);
    rd(F1, d); check("R5 colliding event kept", d, 8'h01);
  endtask

  task automatic t_readonly();
    logic [7:0] d;
    pulse(6'b000001);
    wr(F1, 8'h00);
    wr(F2, 8'hFF);
    rd(F1, d); check("R10 write to flag1 ignored", d, 8'h01);
    rd(F2, d); check("R10 write to flag2 ignored", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hold();
    t_flag1();
    t_flag2();
    t_mask();
    t_gmask();
    t_collide();
    t_readonly();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule